// File: doc/BRIEF.md
# Radio Modem Host Data Port

This block sits between a host controller and the modulator and demodulator of a narrowband radio modem, and moves serial data across that boundary in one of three formats. In the two synchronous formats, plain NRZ and Manchester, the block supplies the bit clock to the host. It takes host transmit bits on the clock's rising edge. It presents received bits so that the host can take them on the same edge. In Manchester format it also turns each transmit bit into a pair of chips, and turns received chip pairs back into bits. The decoder slips by one chip when a pair fails the coding rule. In the transparent asynchronous format the data passes straight through in both directions, and the clock pin holds a configured static level.

Chip timing comes from `baud_tick`, a one-cycle pulse per half bit. Every bit, NRZ or Manchester, takes two ticks, so the Manchester bit rate is half the chip rate. The clock can be qualified by a carrier-sense flag, a PLL-lock flag, or both. While the qualifier is false, the clock stays low and all synchronous state holds. A pin-routing bit chooses between one shared data pin and separate pins. With separate pins, received data goes out on the lock-status pin in the synchronous formats and on the clock pin in the asynchronous format. Format and routing are taken into an internal register only while `tx_en` is low.

Top module: `radio_data_port`

## Requirements
- R1: While reset is asserted, the active format is NRZ, the pin routing is shared and gating is off, with `dclk_o`=0, `mod_data_o`=0, `code_err_o`=0, `dio_oe`=1 and `lock_o` following `pll_lock`.
- R2: In NRZ transmit (`cfg_mode`=0, and 3 also selects NRZ), `dio_i` is taken at the tick that raises `dclk_o`, and `mod_data_o` holds that bit through both halves of the bit.
- R3: In Manchester transmit (`cfg_mode`=2), the bit taken at the rising clock is sent as two chips. The first chip is the bit itself and goes out at the clock rise. The second chip is its complement and goes out at the clock fall, so 0 is sent low-then-high and 1 is sent high-then-low.
- R4: In NRZ receive, `demod_i` is sampled at the tick that lowers `dclk_o`. It appears on the receive data output and stays there until the next falling tick.
- R5: In Manchester receive, a pair of differing chips yields the first chip as the bit. The bit appears while `dclk_o` is low, and `dclk_o` rises at the next tick.
- R6: In Manchester receive, a pair of equal chips raises `code_err_o` for one cycle and emits no bit. The decoder then treats the second chip of the pair as the first chip of the next bit.
- R7: In asynchronous format (`cfg_mode`=1) with shared routing, `mod_data_o` follows `dio_i` combinationally while `tx_en`=1. While `tx_en`=0, `dio_o` follows `demod_i` with `dio_oe`=1. `dclk_o` equals `cfg_idle_lvl` in both directions.
- R8: In asynchronous format with separate routing, `dclk_o` follows `demod_i` while `tx_en`=0 and equals `cfg_idle_lvl` while `tx_en`=1. `dio_oe` stays 0.
- R9: In a synchronous format with separate routing, `lock_o` carries the received data and `dio_oe`=0. With shared routing, `lock_o` follows `pll_lock` and `dio_oe` is the inverse of `tx_en`.
- R10: `cfg_gate` selects the clock qualifier: 0 none, 1 `carrier_sense`, 2 `pll_lock`, 3 both. While the qualifier is false, `dclk_o` is 0 in the synchronous formats and no transmit or receive state advances.
- R11: The configuration inputs take effect only at a clock edge where `tx_en` is low. While `tx_en` is high, changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per half bit (chip rate) |
| tx_en | input | 1 | 1 = transmit direction, 0 = receive direction |
| cfg_mode | input | 2 | 0 NRZ, 1 asynchronous, 2 Manchester, 3 NRZ |
| cfg_sep_pins | input | 1 | 1 = separate receive output pin |
| cfg_idle_lvl | input | 1 | Static clock-pin level in asynchronous format |
| cfg_gate | input | 2 | Clock qualifier select |
| carrier_sense | input | 1 | Carrier-sense flag from the demodulator |
| pll_lock | input | 1 | PLL-lock flag |
| dio_i | input | 1 | Data pin input side (host transmit data) |
| dio_o | output | 1 | Data pin output side (received data) |
| dio_oe | output | 1 | Data pin output enable |
| dclk_o | output | 1 | Data clock pin |
| lock_o | output | 1 | Lock-status pin |
| mod_data_o | output | 1 | Chip or bit stream to the modulator |
| demod_i | input | 1 | Raw data or chips from the demodulator |
| code_err_o | output | 1 | One-cycle Manchester coding-error pulse |

## Verification
In transmit, the bench sends bit sequences that mix runs and alternations. It compares `mod_data_o` at each clock rise and fall, and this separates NRZ holding from Manchester complementing and shows which chip comes first. In receive, the decoder is fed a 0-bit preamble after an idle line, then mixed bits, then a single stray chip. Each of these shows whether the error pulse, the slip and the decoded value are correct. The asynchronous and routing cases toggle the raw inputs in each direction to find which pin carries what. The gating case and the configuration case hold the qualifier false, or change the configuration while transmitting, and show that the clock and the routing keep their earlier behaviour.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    FMT_NRZ   = 2'd0,
    FMT_ASYNC = 2'd1,
    FMT_MANCH = 2'd2
  } fmt_e;

  localparam int GATE_W = 2;

  typedef struct packed {
    fmt_e              fmt;
    logic              sep_pins;
    logic              idle_lvl;
    logic [GATE_W-1:0] gate_sel;
  } port_cfg_t;

  // Code 3 is not a format of its own and falls back to NRZ.
  function automatic fmt_e decode_fmt(input logic [1:0] code);
    case (code)
      2'd1:    return FMT_ASYNC;
      2'd2:    return FMT_MANCH;
      default: return FMT_NRZ;
    endcase
  endfunction

  function automatic logic gate_pass(input logic [GATE_W-1:0] sel,
                                     input logic cs, input logic lk);
    case (sel)
      2'd1:    return cs;
      2'd2:    return lk;
      2'd3:    return cs & lk;
      default: return 1'b1;
    endcase
  endfunction

  // {first chip, second chip}: 0 -> low then high, 1 -> high then low
  function automatic logic [1:0] manch_chips(input logic b);
    return {b, ~b};
  endfunction

endpackage

// File: rtl/rdp_cfg_reg.sv
module rdp_cfg_reg
  import rdp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  port_cfg_t cfg_in,
  output port_cfg_t cfg_q
);

  localparam port_cfg_t CFG_RST = '{fmt: FMT_NRZ, sep_pins: 1'b0,
                                    idle_lvl: 1'b0, gate_sel: '0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RST;
    else if (load_en) cfg_q <= cfg_in;
  end

  // R11: configuration frozen while a transfer holds the port
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cfg_q));

endmodule

// File: rtl/rdp_clkgen.sv
module rdp_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic gate_ok,
  output logic phase,
  output logic tick_q,
  output logic rise_evt,
  output logic fall_evt
);

  assign tick_q   = baud_tick & gate_ok;
  assign rise_evt = tick_q & ~phase;
  assign fall_evt = tick_q & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= 1'b0;
    else if (tick_q) phase <= ~phase;
  end

  // R10: a false qualifier freezes the bit clock
  assert_gate_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |=> $stable(phase));

endmodule

// File: rtl/rdp_tx_path.sv
module rdp_tx_path
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic manch,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic din,
  output logic chip
);

  logic pend;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip  <= 1'b0;
      pend  <= 1'b0;
      armed <= 1'b0;
    end else if (!active) begin
      chip  <= 1'b0;
      pend  <= 1'b0;
      armed <= 1'b0;
    end else if (rise_evt) begin
      {chip, pend} <= manch ? manch_chips(din) : {din, din};
      armed        <= 1'b1;
    end else if (fall_evt && armed) begin
      chip <= pend;
    end
  end

  // R3: the second half of a Manchester bit is the complement of the first
  assert_manch_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && manch && fall_evt && armed) |=> (chip != $past(chip)));

  // R2: NRZ keeps the bit level across the falling half
  assert_nrz_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !manch && fall_evt && armed) |=> $stable(chip));

endmodule

// File: rtl/rdp_rx_path.sv
module rdp_rx_path (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_en,
  input  logic man_en,
  input  logic tick_q,
  input  logic fall_evt,
  input  logic chip_in,
  output logic rx_data,
  output logic rx_clk,
  output logic code_err,
  output logic emit
);

  logic half;
  logic first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= 1'b0;
      rx_clk   <= 1'b0;
      code_err <= 1'b0;
      emit     <= 1'b0;
      half     <= 1'b0;
      first    <= 1'b0;
    end else begin
      code_err <= 1'b0;
      emit     <= 1'b0;
      if (nrz_en && fall_evt) rx_data <= chip_in;
      if (!man_en) begin
        half   <= 1'b0;
        rx_clk <= 1'b0;
      end else if (tick_q) begin
        if (!half) begin
          first  <= chip_in;
          half   <= 1'b1;
          rx_clk <= 1'b1;
        end else if (chip_in != first) begin
          rx_data <= first;
          half    <= 1'b0;
          rx_clk  <= 1'b0;
          emit    <= 1'b1;
        end else begin
          first    <= chip_in;
          code_err <= 1'b1;
        end
      end
    end
  end

  // R6: a pair is either a bit or an error, never both
  assert_err_xor_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({emit, code_err}));

  // R6: after an error the decoder waits for the second chip of a pair
  assert_slip_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> half);

  // R5: fresh decoded data appears while the recovered clock is low
  assert_data_before_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> !rx_clk);

endmodule

// File: rtl/radio_data_port.sv
module radio_data_port
  import rdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_sep_pins,
  input  logic       cfg_idle_lvl,
  input  logic [1:0] cfg_gate,
  input  logic       carrier_sense,
  input  logic       pll_lock,
  input  logic       dio_i,
  output logic       dio_o,
  output logic       dio_oe,
  output logic       dclk_o,
  output logic       lock_o,
  output logic       mod_data_o,
  input  logic       demod_i,
  output logic       code_err_o
);

  port_cfg_t cfg_in, cfg;
  logic gate_ok, is_async, is_manch, sync_fmt;
  logic phase, tick_q, rise_evt, fall_evt;
  logic tx_chip, rx_data, rx_clk, rx_emit;

  always_comb begin
    cfg_in.fmt      = decode_fmt(cfg_mode);
    cfg_in.sep_pins = cfg_sep_pins;
    cfg_in.idle_lvl = cfg_idle_lvl;
    cfg_in.gate_sel = cfg_gate;
  end

  rdp_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(!tx_en), .cfg_in(cfg_in), .cfg_q(cfg)
  );

  assign is_async = (cfg.fmt == FMT_ASYNC);
  assign is_manch = (cfg.fmt == FMT_MANCH);
  assign sync_fmt = !is_async;
  assign gate_ok  = gate_pass(cfg.gate_sel, carrier_sense, pll_lock);

  rdp_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .gate_ok(gate_ok),
    .phase(phase), .tick_q(tick_q), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  rdp_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .active(sync_fmt && tx_en), .manch(is_manch),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .din(dio_i), .chip(tx_chip)
  );

  rdp_rx_path u_rx (
    .clk(clk), .rst_n(rst_n),
    .nrz_en(sync_fmt && !is_manch && !tx_en),
    .man_en(is_manch && !tx_en),
    .tick_q(tick_q), .fall_evt(fall_evt), .chip_in(demod_i),
    .rx_data(rx_data), .rx_clk(rx_clk), .code_err(code_err_o), .emit(rx_emit)
  );

  always_comb begin
    if (is_async)
      dclk_o = (cfg.sep_pins && !tx_en) ? demod_i : cfg.idle_lvl;
    else if (is_manch && !tx_en)
      dclk_o = rx_clk & gate_ok;
    else
      dclk_o = phase & gate_ok;
  end

  assign dio_oe     = !tx_en && !cfg.sep_pins;
  assign dio_o      = is_async ? demod_i : rx_data;
  assign lock_o     = (sync_fmt && cfg.sep_pins) ? rx_data : pll_lock;
  assign mod_data_o = is_async ? (tx_en & dio_i) : tx_chip;

  // R10: a false qualifier keeps the synchronous clock pin low
  assert_gated_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fmt && !gate_ok) |-> !dclk_o);

  // R7: asynchronous shared routing parks the clock pin
  assert_async_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_async && !cfg.sep_pins) |-> (dclk_o == cfg.idle_lvl));

  // R5: a recovered clock rise is never the cycle a new bit lands
  assert_rx_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_emit |-> !dclk_o);

endmodule

// File: tb/radio_data_port_test.sv
module radio_data_port_test;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_sep_pins = 1'b0;
  logic cfg_idle_lvl = 1'b0;
  logic [1:0] cfg_gate = 2'd0;
  logic carrier_sense = 1'b0;
  logic pll_lock = 1'b1;
  logic dio_i = 1'b0;
  logic demod_i = 1'b0;
  logic dio_o, dio_oe, dclk_o, lock_o, mod_data_o, code_err_o;

  int errors = 0;
  int checks = 0;
  logic [1:0] tcnt = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= tcnt + 2'd1;
    baud_tick <= (tcnt == 2'd3);
  end

  radio_data_port uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .cfg_mode(cfg_mode), .cfg_sep_pins(cfg_sep_pins), .cfg_idle_lvl(cfg_idle_lvl),
    .cfg_gate(cfg_gate), .carrier_sense(carrier_sense), .pll_lock(pll_lock),
    .dio_i(dio_i), .dio_o(dio_o), .dio_oe(dio_oe), .dclk_o(dclk_o),
    .lock_o(lock_o), .mod_data_o(mod_data_o), .demod_i(demod_i),
    .code_err_o(code_err_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_dclk(input logic lvl);
    do step(1); while (dclk_o !== lvl);
  endtask

  task automatic send_chip(input logic c);
    demod_i = c;
    do @(posedge clk); while (baud_tick !== 1'b1);
    #1;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic sep, input logic lvl,
                         input logic [1:0] g);
    tx_en = 1'b0;
    cfg_mode = m; cfg_sep_pins = sep; cfg_idle_lvl = lvl; cfg_gate = g;
    step(2);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 dclk", dclk_o, 1'b0);
    chk("R1 mod", mod_data_o, 1'b0);
    chk("R1 oe", dio_oe, 1'b1);
    chk("R1 err", code_err_o, 1'b0);
    chk("R1 lock", lock_o, 1'b1);
    step(5);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_nrz_tx;
    logic [4:0] pat = 5'b10110;
    set_cfg(2'd3, 1'b0, 1'b0, 2'd0);
    tx_en = 1'b1;
    wait_dclk(1'b0);
    for (int i = 0; i < 5; i++) begin
      dio_i = pat[i];
      wait_dclk(1'b1);
      chk("R2 rise", mod_data_o, pat[i]);
      wait_dclk(1'b0);
      chk("R2 fall", mod_data_o, pat[i]);
    end
    chk("R9 oe tx", dio_oe, 1'b0);
  endtask

  task automatic t_manch_tx;
    logic [4:0] pat = 5'b01101;
    set_cfg(2'd2, 1'b0, 1'b0, 2'd0);
    tx_en = 1'b1;
    wait_dclk(1'b0);
    for (int i = 0; i < 5; i++) begin
      dio_i = pat[i];
      wait_dclk(1'b1);
      chk("R3 first chip", mod_data_o, pat[i]);
      wait_dclk(1'b0);
      chk("R3 second chip", mod_data_o, ~pat[i]);
    end
  endtask

  task automatic t_nrz_rx;
    logic [3:0] pat = 4'b0110;
    set_cfg(2'd0, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) begin
      wait_dclk(1'b1);
      demod_i = pat[i];
      wait_dclk(1'b0);
      chk("R4 data", dio_o, pat[i]);
      chk("R9 oe rx", dio_oe, 1'b1);
    end
    pll_lock = 1'b0; #1;
    chk("R9 lock shared", lock_o, 1'b0);
    pll_lock = 1'b1; #1;
    chk("R9 lock shared", lock_o, 1'b1);
  endtask

  task automatic t_manch_rx;
    logic [3:0] pat = 4'b1101;
    set_cfg(2'd2, 1'b0, 1'b0, 2'd0);
    demod_i = 1'b0;
    step(16);
    send_chip(1'b0);
    chk("R6 err on equal pair", code_err_o, 1'b1);
    send_chip(1'b1);
    chk("R5 preamble bit", dio_o, 1'b0);
    chk("R5 clk low at data", dclk_o, 1'b0);
    chk("R6 no err", code_err_o, 1'b0);
    for (int i = 0; i < 4; i++) begin
      send_chip(pat[i]);
      chk("R5 clk rises", dclk_o, 1'b1);
      send_chip(~pat[i]);
      chk("R5 bit", dio_o, pat[i]);
    end
    send_chip(1'b1);
    send_chip(1'b1);
    chk("R6 stray chip err", code_err_o, 1'b1);
    send_chip(1'b0);
    chk("R6 bit after slip", dio_o, 1'b1);
    send_chip(1'b0);
    send_chip(1'b1);
    chk("R6 realigned", dio_o, 1'b0);
  endtask

  task automatic t_async;
    set_cfg(2'd1, 1'b0, 1'b1, 2'd0);
    demod_i = 1'b1; #1;
    chk("R7 rx pass", dio_o, 1'b1);
    chk("R7 oe", dio_oe, 1'b1);
    chk("R7 level", dclk_o, 1'b1);
    demod_i = 1'b0; #1;
    chk("R7 rx pass", dio_o, 1'b0);
    tx_en = 1'b1;
    dio_i = 1'b1; #1;
    chk("R7 tx pass", mod_data_o, 1'b1);
    dio_i = 1'b0; #1;
    chk("R7 tx pass", mod_data_o, 1'b0);
    chk("R7 level tx", dclk_o, 1'b1);
    set_cfg(2'd1, 1'b1, 1'b0, 2'd0);
    demod_i = 1'b1; #1;
    chk("R8 rx on clk", dclk_o, 1'b1);
    chk("R8 oe", dio_oe, 1'b0);
    demod_i = 1'b0; #1;
    chk("R8 rx on clk", dclk_o, 1'b0);
    tx_en = 1'b1; demod_i = 1'b1; #1;
    chk("R8 tx level", dclk_o, 1'b0);
    tx_en = 1'b0;
  endtask

  task automatic t_sep_sync;
    set_cfg(2'd0, 1'b1, 1'b0, 2'd0);
    pll_lock = 1'b0;
    for (int i = 0; i < 2; i++) begin
      wait_dclk(1'b1);
      demod_i = (i == 0);
      wait_dclk(1'b0);
      chk("R9 lock carries data", lock_o, (i == 0));
      chk("R9 oe sep", dio_oe, 1'b0);
    end
    pll_lock = 1'b1;
  endtask

  task automatic t_gate;
    logic seen;
    logic held;
    set_cfg(2'd0, 1'b0, 1'b0, 2'd1);
    carrier_sense = 1'b0;
    held = dio_o;
    demod_i = ~held;
    seen = 1'b0;
    for (int i = 0; i < 24; i++) begin step(1); if (dclk_o) seen = 1'b1; end
    chk("R10 carrier gate low", seen, 1'b0);
    chk("R10 rx held", dio_o, held);
    carrier_sense = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 16; i++) begin step(1); if (dclk_o) seen = 1'b1; end
    chk("R10 carrier pass", seen, 1'b1);
    set_cfg(2'd0, 1'b0, 1'b0, 2'd2);
    pll_lock = 1'b0;
    step(1);
    seen = 1'b0;
    for (int i = 0; i < 24; i++) begin step(1); if (dclk_o) seen = 1'b1; end
    chk("R10 lock gate low", seen, 1'b0);
    pll_lock = 1'b1;
    carrier_sense = 1'b0;
  endtask

  task automatic t_cfg_hold;
    logic hi, lo;
    set_cfg(2'd0, 1'b0, 1'b0, 2'd0);
    tx_en = 1'b1;
    cfg_mode = 2'd1; cfg_idle_lvl = 1'b1;
    hi = 1'b0; lo = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      if (dclk_o) hi = 1'b1; else lo = 1'b1;
    end
    chk("R11 clock still runs", hi & lo, 1'b1);
    dio_i = 1'b1; #1;
    chk("R11 no pass-through", mod_data_o == dio_i && !dclk_o, 1'b0);
    tx_en = 1'b0;
    step(2);
    chk("R11 new level", dclk_o, 1'b1);
    demod_i = 1'b1; #1;
    chk("R11 async rx", dio_o, 1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_nrz_tx();
    t_manch_tx();
    t_nrz_rx();
    t_manch_rx();
    t_async();
    t_sep_sync();
    t_gate();
    t_cfg_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule